// File: doc/BRIEF.md
# Double-Buffered PWM Timer Channel

This block is one down-counting timer channel for a pulse-width modulation tree. A shared prescaler elsewhere supplies a one-cycle tick enable, and the channel decrements its active counter on each tick while it is running. Software sets the period and the duty through two shadow buffers, one for the count and one for the compare value. It can write them at any moment. Neither value touches the active counter or the active compare register until a manual update or an automatic reload moves the buffers across.

A four-bit control word holds start, manual-update, auto-reload and output-invert. The usual sequence has two control writes. The first sets manual-update together with auto-reload, which loads the buffers and parks the channel. The second sets start and clears manual-update in the same write. When the counter sits at zero on a tick, the channel gives a one-cycle expiry pulse. It then either reloads both active registers from the buffers or clears its own start bit and halts. A parameter removes the output pin, so the same channel can serve as an internal tick timer.

Top module: `pwm_dbuf_timer`

## Requirements
- R1: After reset, count_value is 0, running is 0, expire is 0 and pwm_out is 0.
- R2: Writing the count or compare buffer leaves the active counter and the active compare value unchanged. Only a manual update or a reload moves them.
- R3: While manual-update (ctrl_wdata bit 1) is set, the active registers take the buffer values on each clock edge, one cycle behind the buffers, and the counter does not decrement on ticks.
- R4: The channel runs when start (bit 0) is set and manual-update is clear. A running channel decrements count_value by one on each clock where tick_en is high, and it holds the value when tick_en is low. With manual-update set, start alone does not make it count.
- R5: With auto-reload (bit 2) set, a tick at count 0 raises expire for that one cycle and reloads both active registers from the buffers on that edge. A period with count buffer N therefore spans N+1 ticks and has exactly one expiry.
- R6: With auto-reload clear, a tick at count 0 raises expire once, clears start and leaves the counter at 0.
- R7: While running, the output is active whenever count_value is less than or equal to the active compare value. A period with count buffer N and compare C therefore has min(C,N)+1 active ticks.
- R8: When invert (bit 3) is set, pwm_out is the complement of the active level.
- R9: While the channel is not running, pwm_out holds the inactive level, which equals the invert bit.
- R10: With HAS_PIN set to 0, pwm_out is constant 0 and the counter works unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Prescaled tick enable |
| cnt_buf_we | input | 1 | Write strobe for the count buffer |
| cnt_buf_wdata | input | CNT_W | Count buffer write data |
| cmp_buf_we | input | 1 | Write strobe for the compare buffer |
| cmp_buf_wdata | input | CNT_W | Compare buffer write data |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 4 | Control: bit0 start, bit1 manual-update, bit2 auto-reload, bit3 invert |
| count_value | output | CNT_W | Active counter |
| running | output | 1 | Current start bit |
| expire | output | 1 | One-cycle expiry pulse |
| pwm_out | output | 1 | PWM output |

## Verification
The hardest case to reach is the hand-over at zero. In one edge the counter must reload from buffers that software may have changed in the middle of a period, and the expiry pulse must land on exactly that tick. The stimulus loads each period through the two-step control sequence with ticks held off, so the starting count is known. It then drives a continuous tick for exactly N+1 cycles and counts active and expiry samples. After that it checks that the counter is back at N. Buffer writes made with ticks paused show that the active values are not disturbed until a reload.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;
   localparam int CTRL_W = 4;

   // Control word layout, bit 0 upward: start, manual, reload, invert
   typedef struct packed {
      logic invert;
      logic reload;
      logic manual;
      logic start;
   } pwm_ctrl_t;
endpackage

// File: rtl/pwm_tmr_regs.sv
module pwm_tmr_regs
   import pwm_tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cnt_buf_we,
   input  logic [CNT_W-1:0]    cnt_buf_wdata,
   input  logic                cmp_buf_we,
   input  logic [CNT_W-1:0]    cmp_buf_wdata,
   input  logic                ctrl_we,
   input  logic [CTRL_W-1:0]   ctrl_wdata,
   input  logic                halt_evt,
   output logic [CNT_W-1:0]    cnt_buf,
   output logic [CNT_W-1:0]    cmp_buf,
   output pwm_ctrl_t           ctrl
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_buf <= '0;
         cmp_buf <= '0;
      end else begin
         if (cnt_buf_we) cnt_buf <= cnt_buf_wdata;
         if (cmp_buf_we) cmp_buf <= cmp_buf_wdata;
      end
   end

   // A software write wins over the one-shot self-clear
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (ctrl_we) begin
         ctrl <= pwm_ctrl_t'(ctrl_wdata);
      end else if (halt_evt) begin
         ctrl.start <= 1'b0;
      end
   end
endmodule

// File: rtl/pwm_tmr_core.sv
module pwm_tmr_core
   import pwm_tmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  pwm_ctrl_t           ctrl,
   input  logic [CNT_W-1:0]    cnt_buf,
   input  logic [CNT_W-1:0]    cmp_buf,
   output logic [CNT_W-1:0]    count,
   output logic [CNT_W-1:0]    compare,
   output logic                run,
   output logic                zero_hit,
   output logic                halt_evt
);
   logic at_zero;

   always_comb begin
      run      = ctrl.start && !ctrl.manual;
      at_zero  = (count == '0);
      zero_hit = run && tick_en && at_zero;
      halt_evt = zero_hit && !ctrl.reload;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count   <= '0;
         compare <= '0;
      end else if (ctrl.manual) begin
         count   <= cnt_buf;
         compare <= cmp_buf;
      end else if (run && tick_en) begin
         if (at_zero) begin
            if (ctrl.reload) begin
               count   <= cnt_buf;
               compare <= cmp_buf;
            end
         end else begin
            count <= count - 1'b1;
         end
      end
   end
endmodule

// File: rtl/pwm_tmr_out.sv
module pwm_tmr_out #(
   parameter int CNT_W   = 16,
   parameter bit HAS_PIN = 1'b1
) (
   input  logic                run,
   input  logic [CNT_W-1:0]    count,
   input  logic [CNT_W-1:0]    compare,
   input  logic                invert,
   output logic                pwm_out
);
   generate
      if (HAS_PIN) begin : g_pin
         logic active;
         assign active  = run && (count <= compare);
         assign pwm_out = active ^ invert;
      end else begin : g_no_pin
         logic unused_inputs;
         assign unused_inputs = ^{run, count, compare, invert};
         assign pwm_out       = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/pwm_dbuf_timer.sv
module pwm_dbuf_timer
   import pwm_tmr_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter bit HAS_PIN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                cnt_buf_we,
   input  logic [CNT_W-1:0]    cnt_buf_wdata,
   input  logic                cmp_buf_we,
   input  logic [CNT_W-1:0]    cmp_buf_wdata,
   input  logic                ctrl_we,
   input  logic [3:0]          ctrl_wdata,
   output logic [CNT_W-1:0]    count_value,
   output logic                running,
   output logic                expire,
   output logic                pwm_out
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_dbuf_timer: CNT_W must lie in 2..32");
      end
      if (CTRL_W != 4) begin : g_bad_ctrl
         $error("pwm_dbuf_timer: control word must be 4 bits");
      end
   endgenerate

   pwm_ctrl_t          ctrl_q;
   logic [CNT_W-1:0]   cnt_buf, cmp_buf, act_count, act_cmp;
   logic               run, zero_hit, halt_evt;
   logic               c_start, c_manual, c_reload, c_invert;

   assign c_start  = ctrl_q.start;
   assign c_manual = ctrl_q.manual;
   assign c_reload = ctrl_q.reload;
   assign c_invert = ctrl_q.invert;

   pwm_tmr_regs #(.CNT_W(CNT_W)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .cnt_buf_we    (cnt_buf_we),
      .cnt_buf_wdata (cnt_buf_wdata),
      .cmp_buf_we    (cmp_buf_we),
      .cmp_buf_wdata (cmp_buf_wdata),
      .ctrl_we       (ctrl_we),
      .ctrl_wdata    (ctrl_wdata),
      .halt_evt      (halt_evt),
      .cnt_buf       (cnt_buf),
      .cmp_buf       (cmp_buf),
      .ctrl          (ctrl_q)
   );

   pwm_tmr_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .ctrl     (ctrl_q),
      .cnt_buf  (cnt_buf),
      .cmp_buf  (cmp_buf),
      .count    (act_count),
      .compare  (act_cmp),
      .run      (run),
      .zero_hit (zero_hit),
      .halt_evt (halt_evt)
   );

   pwm_tmr_out #(.CNT_W(CNT_W), .HAS_PIN(HAS_PIN)) u_out (
      .run     (run),
      .count   (act_count),
      .compare (act_cmp),
      .invert  (c_invert),
      .pwm_out (pwm_out)
   );

   assign count_value = act_count;
   assign running     = c_start;
   assign expire      = zero_hit;
endmodule

// File: rtl/pwm_tmr_chk.sv
module pwm_tmr_chk #(
   parameter int CNT_W   = 16,
   parameter bit HAS_PIN = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                tick_en,
   input logic                ctrl_we,
   input logic                c_start,
   input logic                c_manual,
   input logic                c_reload,
   input logic                c_invert,
   input logic                run,
   input logic [CNT_W-1:0]    act_count,
   input logic [CNT_W-1:0]    act_cmp,
   input logic                expire,
   input logic                pwm_out
);
   a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_en && !c_manual) |=> act_count == $past(act_count));

   a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
      (run && tick_en && act_count != '0) |=> act_count == $past(act_count) - 1'b1);

   a_r5_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (act_count == '0 && tick_en && c_start));

   a_r6_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !c_reload && !ctrl_we) |=> !c_start);

   a_r2_compare_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (!c_manual && !expire) |=> $stable(act_cmp));

   generate
      if (HAS_PIN) begin : g_pin_chk
         a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
            !run |-> pwm_out == c_invert);
         a_r7_active_level: assert property (@(posedge clk) disable iff (!rst_n)
            (run && act_count <= act_cmp) |-> pwm_out != c_invert);
      end
   endgenerate
endmodule

bind pwm_dbuf_timer pwm_tmr_chk #(.CNT_W(CNT_W), .HAS_PIN(HAS_PIN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .ctrl_we   (ctrl_we),
   .c_start   (c_start),
   .c_manual  (c_manual),
   .c_reload  (c_reload),
   .c_invert  (c_invert),
   .run       (run),
   .act_count (act_count),
   .act_cmp   (act_cmp),
   .expire    (expire),
   .pwm_out   (pwm_out)
);

// File: tb/test_pwm_dbuf_timer.sv
`timescale 1ns/1ps
module test_pwm_dbuf_timer;
   localparam int W = 16;
   // {count buffer, compare buffer, invert}
   localparam logic [2*W:0] VEC [6] = '{
      {16'd5, 16'd2, 1'b0},
      {16'd5, 16'd5, 1'b0},
      {16'd4, 16'd9, 1'b0},
      {16'd6, 16'd0, 1'b1},
      {16'd3, 16'd1, 1'b1},
      {16'd7, 16'd3, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b0;
   logic cnt_buf_we = 1'b0, cmp_buf_we = 1'b0, ctrl_we = 1'b0;
   logic [W-1:0] cnt_buf_wdata = '0, cmp_buf_wdata = '0;
   logic [3:0] ctrl_wdata = '0;
   logic [W-1:0] count_value, np_count;
   logic running, expire, pwm_out, np_running, np_expire, np_pwm;
   int total = 0, bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   pwm_dbuf_timer #(.CNT_W(W), .HAS_PIN(1'b1)) i_pwm_dbuf_timer (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cnt_buf_we(cnt_buf_we), .cnt_buf_wdata(cnt_buf_wdata),
      .cmp_buf_we(cmp_buf_we), .cmp_buf_wdata(cmp_buf_wdata),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .count_value(count_value), .running(running),
      .expire(expire), .pwm_out(pwm_out));

   pwm_dbuf_timer #(.CNT_W(W), .HAS_PIN(1'b0)) i_pwm_dbuf_timer_nopin (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .cnt_buf_we(cnt_buf_we), .cnt_buf_wdata(cnt_buf_wdata),
      .cmp_buf_we(cmp_buf_we), .cmp_buf_wdata(cmp_buf_wdata),
      .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
      .count_value(np_count), .running(np_running),
      .expire(np_expire), .pwm_out(np_pwm));

   task automatic chk(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic buf_wr(input logic [W-1:0] n, input logic [W-1:0] c);
      @(negedge clk);
      cnt_buf_we = 1'b1; cnt_buf_wdata = n;
      cmp_buf_we = 1'b1; cmp_buf_wdata = c;
      @(negedge clk);
      cnt_buf_we = 1'b0; cmp_buf_we = 1'b0;
   endtask

   task automatic ctrl_wr(input logic [3:0] v);
      @(negedge clk);
      ctrl_we = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int n, c, act, ex, np_bad;
      bit inv, last;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 count", count_value, 0);
      chk("R1 running", running, 0);
      chk("R1 expire", expire, 0);
      chk("R1 pwm_out", pwm_out, 0);
      rst_n = 1'b1;

      // Table walk: R5, R7, R8, R9, R10
      np_bad = 0;
      for (int v = 0; v < 6; v++) begin
         n = int'(VEC[v][2*W:W+1]);
         c = int'(VEC[v][W:1]);
         inv = VEC[v][0];
         tick_en = 1'b0;
         buf_wr(W'(n), W'(c));
         ctrl_wr({inv, 1'b1, 1'b1, 1'b0});
         ctrl_wr({inv, 1'b1, 1'b0, 1'b1});
         chk("R3 loaded count", count_value, n);
         tick_en = 1'b1;
         act = 0; ex = 0; last = 1'b0;
         for (int s = 0; s <= n; s++) begin
            if (pwm_out ^ inv) act++;
            if (expire) begin ex++; last = (s == n); end
            if (np_pwm !== 1'b0) np_bad++;
            @(negedge clk);
         end
         tick_en = 1'b0;
         chk("R5 one expiry per period", ex, 1);
         chk("R5 expiry on last tick", last, 1);
         chk("R5 reloaded count", count_value, n);
         chk(inv ? "R8 inverted active ticks" : "R7 active ticks",
             act, ((c < n) ? c : n) + 1);
         ctrl_wr({inv, 1'b1, 1'b1, 1'b0});
         chk("R9 stopped level", pwm_out, inv);
      end
      chk("R10 no-pin output stuck low", np_bad, 0);
      chk("R10 no-pin counter", np_count, count_value);

      // R3 manual update held
      tick_en = 1'b1;
      ctrl_wr(4'b0000);
      buf_wr(16'd10, 16'd0);
      ctrl_wr(4'b0110);
      @(negedge clk);
      chk("R3 follows buffer", count_value, 10);
      repeat (2) @(negedge clk);
      chk("R3 no decrement under manual", count_value, 10);
      buf_wr(16'd20, 16'd0);
      @(negedge clk);
      chk("R3 follows new buffer", count_value, 20);

      // R4 start with manual still set does not count
      ctrl_wr(4'b0111);
      repeat (3) @(negedge clk);
      chk("R4 start+manual holds", count_value, 20);

      // R4 tick gating
      tick_en = 1'b0;
      ctrl_wr(4'b0101);
      repeat (3) @(negedge clk);
      chk("R4 hold without tick", count_value, 20);
      tick_en = 1'b1;
      @(negedge clk);
      chk("R4 first decrement", count_value, 19);
      @(negedge clk);
      tick_en = 1'b0;
      chk("R4 second decrement", count_value, 18);

      // R2 buffer writes leave active state alone
      buf_wr(16'd3, 16'd1);
      chk("R2 count unchanged by buffer write", count_value, 18);
      tick_en = 1'b1;
      @(negedge clk);
      tick_en = 1'b0;
      chk("R2 decrement from active value", count_value, 17);

      // R6 one-shot
      ctrl_wr(4'b0010);
      ctrl_wr(4'b0001);
      chk("R6 one-shot loaded", count_value, 3);
      tick_en = 1'b1;
      ex = 0;
      for (int s = 0; s <= 3; s++) begin
         if (expire) ex++;
         @(negedge clk);
      end
      chk("R6 single expiry", ex, 1);
      chk("R6 start cleared", running, 0);
      chk("R6 count held at zero", count_value, 0);
      repeat (2) @(negedge clk);
      chk("R6 no further expiry", expire, 0);
      chk("R6 still zero", count_value, 0);
      chk("R9 idle level after halt", pwm_out, 0);
      tick_en = 1'b0;
      ctrl_wr(4'b1000);
      chk("R9 idle inverted level", pwm_out, 1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule